// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This controller paces one analog-to-digital conversion cycle for an on-chip converter. When software asserts the enable input with a permitted timing code, the sequencer runs three timed phases in order: a settling phase of fixed length, a conversion phase whose length comes from the timing code, and a short idle wait. The end-of-conversion interrupt is raised when the wait ends, not when the conversion ends. The converter is strobed active only during the conversion phase and is held off during the wait to lower operating current.

A hardware trigger or a control-register write strobe (together the "restart events") disturbs a running cycle in two places. During conversion it discards the work and starts the conversion again. On the final clock of the settling phase it inserts a fresh full settling period, and this can happen any number of times in a row. A timing code whose entry is not permitted never starts a cycle; it sets a sticky error flag. A small stub stands in for the analog result and delivers a value each time a conversion completes. In one-shot mode the sequencer parks in a hold state after the interrupt until a restart event; in repeat mode it starts settling again right away.

The state machine has six states: IDLE (disabled or blocked), SETTLE, CONVERT, REST (the wait), NOTIFY (one clock with the interrupt high) and PARKED. Transitions: IDLE to SETTLE on enable with a permitted code; SETTLE to SETTLE on a restart event on its last clock; SETTLE to CONVERT at its end; CONVERT to CONVERT on a restart event; CONVERT to REST at its end; REST to NOTIFY at its end; NOTIFY to SETTLE in repeat mode, otherwise to PARKED; PARKED to SETTLE on a restart event; any state to IDLE when enable is low.

Top module: `adcseq`

## Requirements
- R1: After reset all outputs are low, the state is IDLE and the error flag is clear.
- R2: With enable high and a permitted code, SETTLE starts on the next clock and lasts STAB_CYCLES clocks (64), then CONVERT lasts CONV_UNIT*(code+1) clocks (26 per step); conv_active is high exactly in CONVERT. The code is captured on entry to SETTLE.
- R3: REST follows CONVERT and lasts WAIT_CYCLES clocks (2) with conv_active low; res_valid pulses for one clock in the first REST clock, and res_data then equals the number of completed conversions since reset, modulo 2^RES_W.
- R4: eoc_irq is a one-clock pulse on the clock after the last REST clock, never during CONVERT.
- R5: A trigger or cfg_write in any CONVERT clock, the last one included, restarts CONVERT for its full length counted from the next clock, and produces no result.
- R6: A trigger or cfg_write on the last SETTLE clock inserts a new full 64-clock SETTLE period, and does so again each time it recurs.
- R7: A restart event in a SETTLE clock other than the last, or in REST, has no effect on phase lengths.
- R8: Codes whose bit in VALID_MASK is zero (by default codes 4 to 15) never start a cycle; code_err is then set and stays set until reset.
- R9: Enable low returns the sequencer to IDLE on the next clock from any state, and an interrupt not yet issued is dropped.
- R10: Without repeat_mode the sequencer parks after the pulse with all phase outputs low, and a restart event starts SETTLE on the next clock; with repeat_mode SETTLE begins on the clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Sequencer enable level |
| repeat_mode | input | 1 | Restart settling after each interrupt |
| trigger | input | 1 | Hardware trigger, restart event |
| cfg_write | input | 1 | Control-register write strobe, restart event |
| timing_code | input | CODE_W | Conversion timing select |
| ph_stab | output | 1 | SETTLE phase indicator |
| ph_conv | output | 1 | CONVERT phase indicator |
| ph_wait | output | 1 | REST phase indicator |
| conv_active | output | 1 | Converter run strobe |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| code_err | output | 1 | Sticky prohibited-code flag |
| res_valid | output | 1 | Result strobe from the stub |
| res_data | output | RES_W | Stub result value |

## Verification
On every cycle the assertions check that at most one phase indicator is high, that the interrupt only follows REST and lasts one clock, that a result only appears at the CONVERT to REST step, that CONVERT is entered only after a whole multiple of the settling length, that a low enable empties every phase and that the error flag never clears. Exact phase lengths for each permitted code, conversion restarts at chosen clocks, repeated settling insertion, ignored events, the result count and the behaviour of every prohibited code are only shown by the bench's scenario sweeps.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_CONVERT,
        SQ_REST,
        SQ_NOTIFY,
        SQ_PARKED
    } sq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adcseq_timing.sv
`timescale 1ns/1ps
// Maps a timing code to a conversion length and a permitted flag.
module adcseq_timing #(
    parameter int          CODE_W     = 4,
    parameter int          CONV_UNIT  = 26,
    parameter int          CNT_W      = 11,
    parameter logic [15:0] VALID_MASK = 16'h000F
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  conv_len_m1,
    output logic              code_ok
);
    localparam int ENTRIES = 1 << CODE_W;

    logic [CNT_W-1:0] len_tab [ENTRIES];
    logic [ENTRIES-1:0] ok_tab;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign len_tab[i] = CNT_W'(CONV_UNIT * (i + 1) - 1);
        assign ok_tab[i]  = (i < 16) ? VALID_MASK[i % 16] : 1'b0;
    end

    assign conv_len_m1 = len_tab[code];
    assign code_ok     = ok_tab[code];
endmodule

// File: rtl/adcseq_downcnt.sv
`timescale 1ns/1ps
// Loadable down counter used for all phase timing.
module adcseq_downcnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         at_zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/adcseq_result_stub.sv
`timescale 1ns/1ps
// Stand-in for the analog result path: counts completed conversions.
module adcseq_result_stub #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data
);
    logic [RES_W-1:0] done_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_cnt_q <= '0;
            res_valid  <= 1'b0;
        end else begin
            res_valid <= conv_done;
            if (conv_done) begin
                done_cnt_q <= done_cnt_q + 1'b1;
            end
        end
    end

    assign res_data = done_cnt_q;
endmodule

// File: rtl/adcseq.sv
`timescale 1ns/1ps
module adcseq #(
    parameter int          CODE_W      = 4,
    parameter int          STAB_CYCLES = 64,
    parameter int          CONV_UNIT   = 26,
    parameter int          WAIT_CYCLES = 2,
    parameter int          RES_W       = 12,
    parameter logic [15:0] VALID_MASK  = 16'h000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              repeat_mode,
    input  logic              trigger,
    input  logic              cfg_write,
    input  logic [CODE_W-1:0] timing_code,
    output logic              ph_stab,
    output logic              ph_conv,
    output logic              ph_wait,
    output logic              conv_active,
    output logic              eoc_irq,
    output logic              code_err,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);
    import adcseq_pkg::*;

    localparam int MAX_LEN = max3(STAB_CYCLES, CONV_UNIT << CODE_W, WAIT_CYCLES);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] STAB_M1 = CNT_W'(STAB_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAIT_M1 = CNT_W'(WAIT_CYCLES - 1);

    sq_state_t         state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              latch_code;
    logic              err_set;
    logic              err_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              conv_done;
    logic              restart_evt;
    logic [CNT_W-1:0]  live_len_m1;
    logic              live_ok;
    logic [CNT_W-1:0]  held_len_m1;
    logic              held_ok;

    assign restart_evt = trigger | cfg_write;

    // Decode of the live code decides whether a cycle may start.
    adcseq_timing #(
        .CODE_W     (CODE_W),
        .CONV_UNIT  (CONV_UNIT),
        .CNT_W      (CNT_W),
        .VALID_MASK (VALID_MASK)
    ) u_live_dec (
        .code        (timing_code),
        .conv_len_m1 (live_len_m1),
        .code_ok     (live_ok)
    );

    // Decode of the captured code supplies the conversion length.
    adcseq_timing #(
        .CODE_W     (CODE_W),
        .CONV_UNIT  (CONV_UNIT),
        .CNT_W      (CNT_W),
        .VALID_MASK (VALID_MASK)
    ) u_held_dec (
        .code        (code_q),
        .conv_len_m1 (held_len_m1),
        .code_ok     (held_ok)
    );

    adcseq_downcnt #(
        .W (CNT_W)
    ) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .at_zero  (cnt_zero)
    );

    adcseq_result_stub #(
        .RES_W (RES_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // State register, captured code and sticky error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            code_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (latch_code) begin
                code_q <= timing_code;
            end
            if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    // Next-state and counter control.
    always_comb begin
        state_d    = state_q;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        latch_code = 1'b0;
        err_set    = 1'b0;
        conv_done  = 1'b0;
        if (!enable) begin
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (live_ok) begin
                        state_d    = SQ_SETTLE;
                        cnt_load   = 1'b1;
                        cnt_val    = STAB_M1;
                        latch_code = 1'b1;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (cnt_zero) begin
                        cnt_load = 1'b1;
                        if (restart_evt) begin
                            cnt_val = STAB_M1;
                        end else begin
                            state_d = SQ_CONVERT;
                            cnt_val = held_len_m1;
                        end
                    end
                end
                SQ_CONVERT: begin
                    if (restart_evt) begin
                        cnt_load = 1'b1;
                        cnt_val  = held_len_m1;
                    end else if (cnt_zero) begin
                        state_d   = SQ_REST;
                        cnt_load  = 1'b1;
                        cnt_val   = WAIT_M1;
                        conv_done = 1'b1;
                    end
                end
                SQ_REST: begin
                    if (cnt_zero) begin
                        state_d = SQ_NOTIFY;
                    end
                end
                SQ_NOTIFY: begin
                    if (!repeat_mode) begin
                        state_d = SQ_PARKED;
                    end else if (live_ok) begin
                        state_d    = SQ_SETTLE;
                        cnt_load   = 1'b1;
                        cnt_val    = STAB_M1;
                        latch_code = 1'b1;
                    end else begin
                        state_d = SQ_IDLE;
                        err_set = 1'b1;
                    end
                end
                SQ_PARKED: begin
                    if (restart_evt) begin
                        if (live_ok) begin
                            state_d    = SQ_SETTLE;
                            cnt_load   = 1'b1;
                            cnt_val    = STAB_M1;
                            latch_code = 1'b1;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Moore outputs.
    always_comb begin
        ph_stab     = 1'b0;
        ph_conv     = 1'b0;
        ph_wait     = 1'b0;
        conv_active = 1'b0;
        eoc_irq     = 1'b0;
        unique case (state_q)
            SQ_IDLE:    ;
            SQ_SETTLE:  ph_stab = 1'b1;
            SQ_CONVERT: begin
                ph_conv     = 1'b1;
                conv_active = held_ok;
            end
            SQ_REST:    ph_wait = 1'b1;
            SQ_NOTIFY:  eoc_irq = 1'b1;
            SQ_PARKED:  ;
            default:    ;
        endcase
    end

    assign code_err = err_q;
endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk #(
    parameter int STAB_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic ph_stab,
    input logic ph_conv,
    input logic ph_wait,
    input logic conv_active,
    input logic eoc_irq,
    input logic code_err,
    input logic res_valid
);
    int stab_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_run <= 0;
        end else begin
            stab_run <= ph_stab ? stab_run + 1 : 0;
        end
    end

    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_stab, ph_conv, ph_wait, eoc_irq}));

    p_settle_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_conv) |-> (stab_run != 0 && (stab_run % STAB_CYCLES) == 0));

    p_res_at_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (ph_wait && $past(ph_conv)));

    p_irq_after_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> $past(ph_wait));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    p_active_in_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_active |-> !ph_wait && !ph_stab);

    p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(ph_stab || ph_conv || ph_wait || eoc_irq));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);
endmodule

bind adcseq adcseq_chk #(
    .STAB_CYCLES (STAB_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .ph_stab     (ph_stab),
    .ph_conv     (ph_conv),
    .ph_wait     (ph_wait),
    .conv_active (conv_active),
    .eoc_irq     (eoc_irq),
    .code_err    (code_err),
    .res_valid   (res_valid)
);

// File: tb/adcseq_test.sv
`timescale 1ns/1ps
module adcseq_test;
    localparam int STAB  = 64;
    localparam int UNIT  = 26;
    localparam int WAITC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        repeat_mode = 1'b0;
    logic        trigger = 1'b0;
    logic        cfg_write = 1'b0;
    logic [3:0]  code = 4'd0;
    logic        ph_stab, ph_conv, ph_wait, conv_active, eoc_irq, code_err, res_valid;
    logic [11:0] res_data;

    int total = 0;
    int bad = 0;
    int exp_res = 0;

    always #2 clk = ~clk;

    adcseq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .repeat_mode (repeat_mode),
        .trigger     (trigger),
        .cfg_write   (cfg_write),
        .timing_code (code),
        .ph_stab     (ph_stab),
        .ph_conv     (ph_conv),
        .ph_wait     (ph_wait),
        .conv_active (conv_active),
        .eoc_irq     (eoc_irq),
        .code_err    (code_err),
        .res_valid   (res_valid),
        .res_data    (res_data)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_evt(input bit use_wr, input bit v);
        trigger   = use_wr ? 1'b0 : v;
        cfg_write = use_wr ? v : 1'b0;
    endtask

    function automatic int phases();
        return {28'd0, ph_stab, ph_conv, ph_wait, eoc_irq};
    endfunction

    // Called at a negedge where SETTLE is being sampled; follows one cycle.
    task automatic observe_run(input int inj_ph, input int at1, input int at2,
                               input bit use_wr, input int exp_stab, input int exp_conv);
        int n;
        int act_cnt;
        n = 0;
        while (ph_stab && n < 5000) begin
            n++;
            set_evt(use_wr, inj_ph == 1 && (n == at1 || n == at2));
            @(negedge clk);
        end
        set_evt(use_wr, 1'b0);
        chk_eq("R2/R6/R7 settle clocks", n, exp_stab);
        n = 0;
        act_cnt = 0;
        while (ph_conv && n < 5000) begin
            n++;
            if (conv_active) act_cnt++;
            set_evt(use_wr, inj_ph == 2 && (n == at1 || n == at2));
            @(negedge clk);
        end
        set_evt(use_wr, 1'b0);
        chk_eq("R2/R5 convert clocks", n, exp_conv);
        chk_eq("R2 conv_active clocks", act_cnt, exp_conv);
        exp_res++;
        chk_eq("R3 res_valid in first rest clock", int'(res_valid), 1);
        chk_eq("R3 res_data count", int'(res_data), exp_res % 4096);
        n = 0;
        act_cnt = 0;
        while (ph_wait && n < 5000) begin
            n++;
            if (conv_active) act_cnt++;
            set_evt(use_wr, inj_ph == 3 && (n == at1 || n == at2));
            @(negedge clk);
        end
        set_evt(use_wr, 1'b0);
        chk_eq("R3/R7 rest clocks", n, WAITC);
        chk_eq("R3 converter off in rest", act_cnt, 0);
        chk_eq("R4 irq after rest", int'(eoc_irq), 1);
        @(negedge clk);
        chk_eq("R4 irq one clock", int'(eoc_irq), 0);
    endtask

    task automatic start_and_run(input int c, input int inj_ph, input int at1, input int at2,
                                 input bit use_wr, input int exp_stab, input int exp_conv);
        code   = 4'(c);
        enable = 1'b1;
        @(negedge clk);
        observe_run(inj_ph, at1, at2, use_wr, exp_stab, exp_conv);
    endtask

    task automatic stop();
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int irqs;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk_eq("R1 phases in reset", phases(), 0);
        chk_eq("R1 error in reset", int'(code_err), 0);
        chk_eq("R1 result strobe in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 idle after reset", phases() + int'(conv_active), 0);

        // R2/R3/R4/R10 sweep over every permitted code, one-shot mode
        for (int c = 0; c < 4; c++) begin
            start_and_run(c, 0, 0, 0, 1'b0, STAB, UNIT * (c + 1));
            repeat (3) @(negedge clk);
            chk_eq("R10 parked phases low", phases(), 0);
            stop();
        end

        // R6 single and repeated settle insertion, trigger and write
        start_and_run(1, 1, STAB, 0, 1'b0, 2 * STAB, 2 * UNIT);
        stop();
        start_and_run(1, 1, STAB, 2 * STAB, 1'b1, 3 * STAB, 2 * UNIT);
        stop();

        // R7 events ignored mid-settle and in rest
        start_and_run(1, 1, 30, 1, 1'b0, STAB, 2 * UNIT);
        stop();
        start_and_run(1, 3, 1, 2, 1'b1, STAB, 2 * UNIT);
        stop();

        // R5 conversion restarts, mid and on last clock
        start_and_run(1, 2, 10, 0, 1'b0, STAB, 10 + 2 * UNIT);
        stop();
        start_and_run(1, 2, 2 * UNIT, 0, 1'b1, STAB, 4 * UNIT);
        stop();
        start_and_run(0, 2, 5, 20, 1'b0, STAB, 20 + UNIT);
        stop();

        // R10 parked restart by trigger
        start_and_run(0, 0, 0, 0, 1'b0, STAB, UNIT);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk_eq("R10 trigger leaves parked", int'(ph_stab), 1);
        observe_run(0, 0, 0, 1'b0, STAB, UNIT);
        stop();

        // R10 repeat mode then R9 drop in settle
        repeat_mode = 1'b1;
        start_and_run(2, 0, 0, 0, 1'b0, STAB, 3 * UNIT);
        chk_eq("R10 repeat resettles", int'(ph_stab), 1);
        observe_run(0, 0, 0, 1'b0, STAB, 3 * UNIT);
        stop();
        chk_eq("R9 idle from settle", phases(), 0);
        repeat_mode = 1'b0;

        // R9 drop during conversion
        code = 4'd0;
        enable = 1'b1;
        repeat (STAB + 5) @(negedge clk);
        chk_eq("R9 in convert before drop", int'(ph_conv), 1);
        enable = 1'b0;
        @(negedge clk);
        chk_eq("R9 idle from convert", phases() + int'(conv_active), 0);
        irqs = 0;
        repeat (100) begin
            @(negedge clk);
            if (eoc_irq) irqs++;
        end
        chk_eq("R9 no irq after drop", irqs, 0);

        // R9 drop on last rest clock drops the pending pulse
        enable = 1'b1;
        repeat (STAB + UNIT + WAITC) @(negedge clk);
        exp_res++;
        chk_eq("R9 on last rest clock", int'(ph_wait), 1);
        enable = 1'b0;
        irqs = 0;
        repeat (10) begin
            @(negedge clk);
            if (eoc_irq) irqs++;
        end
        chk_eq("R9 pending irq dropped", irqs, 0);
        chk_eq("R3 count kept", int'(res_data), exp_res % 4096);

        // R8 every prohibited code
        for (int c = 4; c < 16; c++) begin
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            exp_res = 0;
            chk_eq("R8 error clear after reset", int'(code_err), 0);
            code = 4'(c);
            enable = 1'b1;
            repeat (3) @(negedge clk);
            chk_eq("R8 no start on prohibited code", phases(), 0);
            chk_eq("R8 error set", int'(code_err), 1);
            if (c == 15) begin
                code = 4'd0;
                @(negedge clk);
                chk_eq("R8 start with permitted code", int'(ph_stab), 1);
                chk_eq("R8 error still set", int'(code_err), 1);
            end
            stop();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule